// File: doc/BRIEF.md
# ADC Control Register Sequencer

This block is the register-mapped front end of one shared analog-to-digital converter. A CPU reaches it through a small register bus. Address 0 holds a control/status byte with a start bit, a read-only busy flag and a channel field. Address 1 holds a pin-configuration byte. From these registers the block drives a select for the analog multiplexer, one analog-enable line per pin and a power-enable for the converter. It also sequences the reset, launch and completion of each conversion. The converter core is modelled as a fixed-length cycle count that ends by capturing the `sample_in` word into `conv_result`.

Software starts a conversion with two writes. The first write sets start, which resets the converter and raises busy. The second write clears start, which launches the conversion. Busy falls in the same cycle that the result is captured. A state machine with five states tracks this:

- `ST_IDLE_RST`: the state after reset. Busy is high and no conversion has run yet.
- `ST_HOLD`: start is high, so the converter is held in reset.
- `ST_PEND`: start has been released, but every pin bit is 0, so the converter is unpowered. The block waits here for power.
- `ST_CONV`: the cycle counter is running.
- `ST_DONE`: the result has been captured and busy is low.

The transitions are:

- From any state, a start rising write goes to `ST_HOLD`.
- From `ST_HOLD`, the start falling write goes to `ST_CONV` if the converter is powered, and to `ST_PEND` if it is not.
- From `ST_PEND`, power-on goes to `ST_CONV`.
- From `ST_CONV`, reaching the last count goes to `ST_DONE`.
- From `ST_CONV`, losing power goes to `ST_PEND`.

Top module: `adcseq_top`

## Requirements
- R1: After reset, address 0 reads 0x40 (start 0, busy 1, channel 000), address 1 reads 0x00, `ana_en` is 0 and `conv_pwr_en` is 0.
- R2: A write to address 0 with bit 7 = 1 while start is 0 raises busy from the next cycle and abandons any conversion in progress.
- R3: While start stays 1, no conversion runs and busy stays 1, for any number of cycles.
- R4: Take the cycle of the write that clears start while the converter is powered. Busy falls exactly CONV_CYCLES clock edges later (default 16). In that same edge, `conv_result` captures `sample_in`. `conv_result` changes at no other time.
- R5: The address 0 layout is: bit 7 start (read/write), bit 6 busy (read-only), bits 5..3 read 0, bits 2..0 channel (read/write). Written values in bits 6..3 have no effect.
- R6: `mux_sel` decodes the channel field as follows: 000→0, 001→1, 010→2, 011→3, 100/101/110→4, 111→3.
- R7: Address 1 bits 4..0 are read/write pin bits and bits 7..5 read 0. `ana_en[i]` equals pin bit i. `conv_pwr_en` is 1 when any pin bit is 1.
- R8: If start is cleared while every pin bit is 0, busy stays 1 and no conversion runs. The first write that sets a pin bit starts the conversion, and busy falls CONV_CYCLES+1 edges after that write.
- R9: A new start rising write during a conversion aborts it. Busy stays 1, `conv_result` keeps its old value, and the next start falling write runs a full CONV_CYCLES conversion.
- R10: Clearing every pin bit during a conversion aborts it with busy held at 1. When a pin bit is set again, a full conversion runs and ends CONV_CYCLES+1 edges after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 = control/status, 1 = pin configuration |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sample_in | input | RES_W | Converter output word, captured at the end of a conversion |
| conv_result | output | RES_W | Last captured result |
| mux_sel | output | 3 | Analog multiplexer input index (0..4) |
| ana_en | output | NPIN | Per-pin analog enable |
| conv_pwr_en | output | 1 | Converter power enable |

## Verification
The hardest situations to reach are the aborted conversions. A start rising write, or the loss of all pin bits, has to land in the middle of the count. After that, busy must be seen to stay high well past the nominal length while the old result stays unchanged. The directed tasks launch a conversion, wait a few cycles, and then issue the aborting write. They hold `sample_in` at a different value from the one captured before, so that any capture by the aborted run would show up. The unpowered-launch case is reached by releasing start while address 1 is zero, then enabling a pin many cycles later.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_RST = 3'd0,
        ST_HOLD     = 3'd1,
        ST_PEND     = 3'd2,
        ST_CONV     = 3'd3,
        ST_DONE     = 3'd4
    } seq_state_e;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_PINS = 1'b1;

    // Channel field to multiplexer input, with aliased codes.
    function automatic logic [2:0] chan_route(input logic [2:0] code);
        logic [2:0] idx;
        case (code)
            3'd0, 3'd1, 3'd2, 3'd3: idx = code;
            3'd4, 3'd5, 3'd6:       idx = 3'd4;
            default:                idx = 3'd3;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/adcseq_regs.sv
module adcseq_regs #(
    parameter int NPIN = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_addr,
    input  logic [7:0]      bus_wdata,
    input  logic            busy,
    output logic [7:0]      bus_rdata,
    output logic            start_q,
    output logic [2:0]      chan_q,
    output logic [NPIN-1:0] pins_q,
    output logic            start_rise,
    output logic            start_fall
);
    import adcseq_pkg::*;

    localparam int PAD_W = 8 - NPIN;

    logic wr_ctrl;
    logic wr_pins;

    assign wr_ctrl    = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_pins    = bus_wr && (bus_addr == ADDR_PINS);
    assign start_rise = wr_ctrl &&  bus_wdata[7] && !start_q;
    assign start_fall = wr_ctrl && !bus_wdata[7] &&  start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            chan_q  <= 3'd0;
        end else if (wr_ctrl) begin
            start_q <= bus_wdata[7];
            chan_q  <= bus_wdata[2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '0;
        end else if (wr_pins) begin
            pins_q <= bus_wdata[NPIN-1:0];
        end
    end

    always_comb begin
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata = {start_q, busy, 3'b000, chan_q};
        end else begin
            bus_rdata = {{PAD_W{1'b0}}, pins_q};
        end
    end

endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rise,
    input  logic start_fall,
    input  logic pwr_on,
    input  logic last_cycle,
    output logic busy,
    output logic conv_run,
    output logic finish
);
    import adcseq_pkg::*;

    seq_state_e state_q;
    seq_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_rise) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_IDLE_RST: state_d = ST_IDLE_RST;
                ST_HOLD: begin
                    if (start_fall) state_d = pwr_on ? ST_CONV : ST_PEND;
                end
                ST_PEND: begin
                    if (pwr_on) state_d = ST_CONV;
                end
                ST_CONV: begin
                    if (!pwr_on)         state_d = ST_PEND;
                    else if (last_cycle) state_d = ST_DONE;
                end
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE_RST;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE_RST;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy     = 1'b1;
        conv_run = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE_RST, ST_HOLD, ST_PEND: begin
                busy = 1'b1;
            end
            ST_CONV: begin
                conv_run = 1'b1;
                finish   = pwr_on && last_cycle && !start_rise;
            end
            ST_DONE: begin
                busy = 1'b0;
            end
            default: begin
                busy = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/adcseq_conv.sv
module adcseq_conv #(
    parameter int CONV_CYCLES = 16,
    parameter int RES_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_run,
    input  logic             finish,
    input  logic [RES_W-1:0] sample_in,
    output logic             last_cycle,
    output logic [RES_W-1:0] result_q
);
    localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last_cycle = (cnt_q == LAST);

    // The count restarts whenever the sequencer leaves the converting state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!conv_run || finish) begin
            cnt_q <= '0;
        end else if (!last_cycle) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      result_q <= '0;
        else if (finish) result_q <= sample_in;
    end

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
    parameter int NPIN        = 5,
    parameter int CONV_CYCLES = 16,
    parameter int RES_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [RES_W-1:0] sample_in,
    output logic [RES_W-1:0] conv_result,
    output logic [2:0]       mux_sel,
    output logic [NPIN-1:0]  ana_en,
    output logic             conv_pwr_en
);
    import adcseq_pkg::*;

    logic            start_q;
    logic [2:0]      chan_q;
    logic [NPIN-1:0] pins_q;
    logic            start_rise;
    logic            start_fall;
    logic            busy;
    logic            conv_run;
    logic            finish;
    logic            last_cycle;
    logic            pwr_on;

    assign pwr_on      = |pins_q;
    assign conv_pwr_en = pwr_on;
    assign ana_en      = pins_q;
    assign mux_sel     = chan_route(chan_q);

    adcseq_regs #(.NPIN(NPIN)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .bus_rdata (bus_rdata),
        .start_q   (start_q),
        .chan_q    (chan_q),
        .pins_q    (pins_q),
        .start_rise(start_rise),
        .start_fall(start_fall)
    );

    adcseq_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rise(start_rise),
        .start_fall(start_fall),
        .pwr_on    (pwr_on),
        .last_cycle(last_cycle),
        .busy      (busy),
        .conv_run  (conv_run),
        .finish    (finish)
    );

    adcseq_conv #(.CONV_CYCLES(CONV_CYCLES), .RES_W(RES_W)) conv_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_run  (conv_run),
        .finish    (finish),
        .sample_in (sample_in),
        .last_cycle(last_cycle),
        .result_q  (conv_result)
    );

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_q,
    input logic             start_rise,
    input logic             busy,
    input logic             conv_run,
    input logic             conv_pwr_en,
    input logic [RES_W-1:0] conv_result
);
    // R2: a start rising write makes busy high and stops any conversion.
    a_r2_rise_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_rise |=> (busy && !conv_run));

    // R3: while start is held at 1, the converter does not run.
    a_r3_held_no_conv: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> !conv_run);

    // R8: without power, no conversion runs in the next cycle.
    a_r8_unpowered_no_conv: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_pwr_en |=> !conv_run);

    // R4: busy only falls at the end of a conversion.
    a_r4_done_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(conv_run));

    // R4, R9: the result only changes together with busy falling.
    a_r9_result_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(conv_result) |-> $fell(busy));
endmodule

bind adcseq_top adcseq_chk #(.RES_W(RES_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_q    (start_q),
    .start_rise (start_rise),
    .busy       (busy),
    .conv_run   (conv_run),
    .conv_pwr_en(conv_pwr_en),
    .conv_result(conv_result)
);

// File: tb/adcseq_top_tb_top.sv
module adcseq_top_tb_top;
    localparam int NPIN  = 5;
    localparam int NCYC  = 16;
    localparam int RES_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic             bus_addr = 1'b0;
    logic [7:0]       bus_wdata = 8'h00;
    logic [7:0]       bus_rdata;
    logic [RES_W-1:0] sample_in = '0;
    logic [RES_W-1:0] conv_result;
    logic [2:0]       mux_sel;
    logic [NPIN-1:0]  ana_en;
    logic             conv_pwr_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    adcseq_top #(.NPIN(NPIN), .CONV_CYCLES(NCYC), .RES_W(RES_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_in(sample_in),
        .conv_result(conv_result), .mux_sel(mux_sel), .ana_en(ana_en),
        .conv_pwr_en(conv_pwr_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic busy_now();
        return bus_rdata[6];
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        rd(1'b0, d); check("R1 ctrl reset", d, 8'h40);
        rd(1'b1, d); check("R1 pins reset", d, 8'h00);
        check("R1 ana_en reset", ana_en, 0);
        check("R1 pwr reset", conv_pwr_en, 0);
    endtask

    task automatic t_layout_and_chan();
        logic [7:0] d;
        wr(1'b0, 8'b0111_1010);          // bits 6..3 set, channel 010
        rd(1'b0, d); check("R5 ignored bits", d, 8'h42);
        for (int c = 0; c < 8; c++) begin
            wr(1'b0, 8'(c));
            check("R6 channel decode", mux_sel, (c < 4) ? c : (c == 7) ? 3 : 4);
        end
        wr(1'b1, 8'hF5);
        rd(1'b1, d); check("R7 pin readback", d, 8'h15);
        check("R7 ana_en", ana_en, 5'h15);
        check("R7 pwr on", conv_pwr_en, 1);
    endtask

    task automatic t_conversion(input logic [RES_W-1:0] s);
        logic [7:0] d;
        sample_in = s;
        wr(1'b0, 8'h81);
        rd(1'b0, d); check("R2 busy after rise", d, 8'hC1);
        wait_cyc(40);
        rd(1'b0, d); check("R3 held busy", busy_now(), 1);
        wr(1'b0, 8'h01);
        wait_cyc(NCYC - 1);
        rd(1'b0, d); check("R4 busy before end", busy_now(), 1);
        wait_cyc(1);
        rd(1'b0, d); check("R4 busy cleared", d, 8'h01);
        check("R4 result", conv_result, s);
    endtask

    task automatic t_unpowered();
        logic [7:0] d;
        wr(1'b1, 8'h00);
        check("R7 pwr off", conv_pwr_en, 0);
        sample_in = 10'h155;
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h00);
        wait_cyc(3 * NCYC);
        rd(1'b0, d); check("R8 stays busy unpowered", busy_now(), 1);
        check("R8 result unchanged", conv_result, 10'h2AB);
        wr(1'b1, 8'h04);
        wait_cyc(NCYC);
        rd(1'b0, d); check("R8 busy before end", busy_now(), 1);
        wait_cyc(1);
        rd(1'b0, d); check("R8 busy cleared", busy_now(), 0);
        check("R8 result", conv_result, 10'h155);
    endtask

    task automatic t_restart_abort();
        logic [7:0] d;
        sample_in = 10'h0F0;
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h00);
        wait_cyc(4);
        sample_in = 10'h3C3;
        wr(1'b0, 8'h80);                 // abort mid-conversion
        wait_cyc(2 * NCYC);
        rd(1'b0, d); check("R9 busy held", busy_now(), 1);
        check("R9 old result kept", conv_result, 10'h155);
        wr(1'b0, 8'h00);
        wait_cyc(NCYC - 1);
        rd(1'b0, d); check("R9 busy before end", busy_now(), 1);
        wait_cyc(1);
        rd(1'b0, d); check("R9 busy cleared", busy_now(), 0);
        check("R9 new result", conv_result, 10'h3C3);
    endtask

    task automatic t_power_abort();
        logic [7:0] d;
        sample_in = 10'h011;
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h00);
        wait_cyc(5);
        wr(1'b1, 8'h00);                 // power lost mid-conversion
        wait_cyc(2 * NCYC);
        rd(1'b0, d); check("R10 busy held", busy_now(), 1);
        check("R10 old result kept", conv_result, 10'h3C3);
        wr(1'b1, 8'h10);
        wait_cyc(NCYC);
        rd(1'b0, d); check("R10 busy before end", busy_now(), 1);
        wait_cyc(1);
        rd(1'b0, d); check("R10 busy cleared", busy_now(), 0);
        check("R10 result", conv_result, 10'h011);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_layout_and_chan();
        t_conversion(10'h2AB);
        t_unpowered();
        t_restart_abort();
        t_power_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule